// File: doc/BRIEF.md
# Multiphase Regulator Fault Supervisor

This block is the digital protection supervisor of a multiphase buck regulator. It watches two comparator flags, one for overcurrent and one for overvoltage, together with an enable-level input and a supply-good input. From these it decides, cycle by cycle, what every phase driver is told to do: switch normally under PWM control, hold its low-side switch on, or float its input so the external driver turns both switches off.

An overcurrent trip shuts the converter down by floating all phases. It then waits a programmable number of clock cycles and asks the soft-start logic to restart. An overvoltage trip latches. While the overvoltage condition is present, all low-side switches are held on. When the condition goes away, the phases float. They are clamped again each time the condition returns. Normal switching does not resume until the enable or supply-good input drops. Dropping either of them clears every fault and arms a soft-start request for the next enable.

The two fault flags are asynchronous. Each passes through a two-flop synchronizer and is accepted only after two consecutive synchronized samples are high.

Top module: `vr_fault_guard`

## Requirements
- R1: While reset is applied and just after it is released with the block disabled, every phase reads tri-state (code 2'b10), `ovp_o` is 0 and `ss_restart_o` is 0.
- R2: When `en_ok_i` and `por_ok_i` are both high and no fault is present, the block leaves the disabled state on the next clock edge. Every phase then reads PWM (code 2'b00) and `ss_restart_o` is high for exactly that first cycle.
- R3: A raw fault flag counts only after two consecutive synchronized samples are high. A raw pulse lasting one clock has no effect. A pulse of two or more clocks changes the outputs on the fourth rising edge after its first sampled edge.
- R4: A valid overcurrent flag in normal operation puts every phase in tri-state for exactly `HICCUP_CYC` clock cycles.
- R5: When the hiccup time expires, every phase returns to PWM and `ss_restart_o` is high for that one cycle only.
- R6: A valid overvoltage flag drives every phase to low-side-on (code 2'b01) and sets `ovp_o`.
- R7: While the overvoltage fault is latched, every phase reads tri-state when the qualified flag drops and low-side-on again when it returns, for as many recurrences as occur.
- R8: Once the overvoltage fault is latched, `ovp_o` stays high and no phase reads PWM for as long as enable and supply-good stay high.
- R9: Lowering `en_ok_i` or `por_ok_i` returns the block to the disabled state on the next edge: all phases tri-state, `ovp_o` cleared, any hiccup wait abandoned. Re-enabling produces a fresh `ss_restart_o` pulse.
- R10: When qualified overcurrent and overvoltage flags are both active in the same cycle, the overvoltage response is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ok_i | input | 1 | Enable level, high when the enable pin is above its on threshold |
| por_ok_i | input | 1 | Supply-good, high once the internal power-on reset has released |
| oc_raw_i | input | 1 | Asynchronous overcurrent comparator flag |
| ov_raw_i | input | 1 | Asynchronous overvoltage comparator flag |
| phase_mode_o | output | 2*NUM_PHASES | Per-phase command, 2 bits per phase, phase k at [2k+1:2k]: 00 PWM, 01 low-side on, 10 tri-state |
| ovp_o | output | 1 | Overvoltage indication, high while the overvoltage fault is latched |
| ss_restart_o | output | 1 | One-cycle soft-start restart request |

## Verification
The hardest state to reach is an overvoltage recurrence inside the latch: the qualified flag has to fall and rise again while the block stays latched. The pulses must be long enough to pass the two-sample qualifier and the gaps long enough to clear it. The bench drives timed overvoltage bursts separated by gaps of several clocks and checks the clamp and float alternation at fixed cycles. It then sweeps fault pulse widths and gaps across the qualifier boundary, and finishes with a long random run of flags and enable drops. A cycle model in the bench checks every output on every cycle.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

    // Per-phase command encoding seen by the external drivers.
    typedef enum logic [1:0] {
        PH_PWM = 2'b00,
        PH_LOW = 2'b01,
        PH_TRI = 2'b10
    } ph_mode_e;

    // Supervisor states.
    typedef enum logic [1:0] {
        ST_OFF     = 2'b00,
        ST_RUN     = 2'b01,
        ST_HICCUP  = 2'b10,
        ST_OVLATCH = 2'b11
    } sup_state_e;

endpackage

// File: rtl/vfg_flag_qual.sv
module vfg_flag_qual #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic valid_o
);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] pipe;
        logic                  hold;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d      = q_q;
        q_d.pipe = {q_q.pipe[SYNC_DEPTH-2:0], raw_i};
        q_d.hold = q_q.pipe[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // Flag is accepted only after two consecutive synchronized samples are high.
    assign valid_o = q_q.pipe[SYNC_DEPTH-1] & q_q.hold;

    // R3
    qual_two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(raw_i, SYNC_DEPTH) && $past(raw_i, SYNC_DEPTH + 1)));

endmodule

// File: rtl/vfg_core.sv
module vfg_core
    import vfg_pkg::*;
#(
    parameter int HICCUP_CYC = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_ok_i,
    input  logic       por_ok_i,
    input  logic       oc_valid_i,
    input  logic       ov_valid_i,
    output sup_state_e state_o,
    output logic       ov_low_o,
    output logic       ss_restart_o
);

    localparam int CNT_W = (HICCUP_CYC > 2) ? $clog2(HICCUP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HICCUP_CYC - 1);

    typedef struct packed {
        sup_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             ov_low;
        logic             ss;
    } core_t;

    core_t c_d, c_q;
    logic  active;

    assign active = en_ok_i & por_ok_i;

    always_comb begin
        c_d    = c_q;
        c_d.ss = 1'b0;
        if (!active) begin
            c_d.state  = ST_OFF;
            c_d.cnt    = '0;
            c_d.ov_low = 1'b0;
        end else begin
            unique case (c_q.state)
                ST_OFF: begin
                    c_d.state = ST_RUN;
                    c_d.ss    = 1'b1;
                end
                ST_RUN: begin
                    if (ov_valid_i) begin
                        c_d.state  = ST_OVLATCH;
                        c_d.ov_low = 1'b1;
                    end else if (oc_valid_i) begin
                        c_d.state = ST_HICCUP;
                        c_d.cnt   = CNT_LOAD;
                    end
                end
                ST_HICCUP: begin
                    if (ov_valid_i) begin
                        c_d.state  = ST_OVLATCH;
                        c_d.ov_low = 1'b1;
                        c_d.cnt    = '0;
                    end else if (c_q.cnt == '0) begin
                        c_d.state = ST_RUN;
                        c_d.ss    = 1'b1;
                    end else begin
                        c_d.cnt = c_q.cnt - 1'b1;
                    end
                end
                ST_OVLATCH: begin
                    c_d.ov_low = ov_valid_i;
                end
                default: c_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_OFF;
            c_q.cnt    <= '0;
            c_q.ov_low <= 1'b0;
            c_q.ss     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_o      = c_q.state;
    assign ov_low_o     = c_q.ov_low;
    assign ss_restart_o = c_q.ss;

    // R4
    hiccup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_HICCUP && c_q.cnt != '0 && active && !ov_valid_i)
        |=> (c_q.state == ST_HICCUP));

    // R5
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.ss |=> !c_q.ss);

    // R8
    ov_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_OVLATCH && active) |=> (c_q.state == ST_OVLATCH));

    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (c_q.state == ST_OFF && !c_q.ov_low && !c_q.ss));

    // R10
    ov_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RUN && active && oc_valid_i && ov_valid_i)
        |=> (c_q.state == ST_OVLATCH && c_q.ov_low));

endmodule

// File: rtl/vfg_phase_map.sv
module vfg_phase_map
    import vfg_pkg::*;
(
    input  sup_state_e state_i,
    input  logic       ov_low_i,
    output logic [1:0] mode_o
);

    ph_mode_e mode;

    always_comb begin
        unique case (state_i)
            ST_RUN:     mode = PH_PWM;
            ST_OVLATCH: mode = ov_low_i ? PH_LOW : PH_TRI;
            default:    mode = PH_TRI;
        endcase
    end

    assign mode_o = mode;

endmodule

// File: rtl/vr_fault_guard.sv
module vr_fault_guard
    import vfg_pkg::*;
#(
    parameter int NUM_PHASES = 6,
    parameter int HICCUP_CYC = 50000,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_ok_i,
    input  logic                    por_ok_i,
    input  logic                    oc_raw_i,
    input  logic                    ov_raw_i,
    output logic [2*NUM_PHASES-1:0] phase_mode_o,
    output logic                    ovp_o,
    output logic                    ss_restart_o
);

    logic       oc_valid;
    logic       ov_valid;
    sup_state_e state;
    logic       ov_low;

    vfg_flag_qual #(.SYNC_DEPTH(SYNC_DEPTH)) i_oc_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (oc_raw_i),
        .valid_o (oc_valid)
    );

    vfg_flag_qual #(.SYNC_DEPTH(SYNC_DEPTH)) i_ov_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (ov_raw_i),
        .valid_o (ov_valid)
    );

    vfg_core #(.HICCUP_CYC(HICCUP_CYC)) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_ok_i      (en_ok_i),
        .por_ok_i     (por_ok_i),
        .oc_valid_i   (oc_valid),
        .ov_valid_i   (ov_valid),
        .state_o      (state),
        .ov_low_o     (ov_low),
        .ss_restart_o (ss_restart_o)
    );

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        vfg_phase_map i_map (
            .state_i  (state),
            .ov_low_i (ov_low),
            .mode_o   (phase_mode_o[2*g +: 2])
        );
    end

    assign ovp_o = (state == ST_OVLATCH);

    // R6
    ov_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_ok_i && por_ok_i && ov_valid)
        |=> (ovp_o && phase_mode_o[1:0] == 2'b01));

    // R8
    no_pwm_in_ovp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_o |-> (phase_mode_o[1:0] != 2'b00));

endmodule

// File: tb/test_vr_fault_guard.sv
module test_vr_fault_guard;

    localparam int NPH  = 4;
    localparam int HCYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_ok = 1'b0;
    logic por_ok = 1'b1;
    logic oc_raw = 1'b0;
    logic ov_raw = 1'b0;
    logic [2*NPH-1:0] phase_mode;
    logic ovp;
    logic ss_restart;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;

    always #10 clk = ~clk;

    vr_fault_guard #(.NUM_PHASES(NPH), .HICCUP_CYC(HCYC)) i_vr_fault_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_ok_i      (en_ok),
        .por_ok_i     (por_ok),
        .oc_raw_i     (oc_raw),
        .ov_raw_i     (ov_raw),
        .phase_mode_o (phase_mode),
        .ovp_o        (ovp),
        .ss_restart_o (ss_restart)
    );

    // Reference model built from the requirements: 0 off, 1 run, 2 hiccup, 3 ov latched.
    int m_state = 0;
    int m_cnt = 0;
    bit m_low = 0, m_ss = 0;
    bit m_oc1 = 0, m_oc2 = 0, m_oc3 = 0;
    bit m_ov1 = 0, m_ov2 = 0, m_ov3 = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_low <= 0; m_ss <= 0;
            m_oc1 <= 0; m_oc2 <= 0; m_oc3 <= 0;
            m_ov1 <= 0; m_ov2 <= 0; m_ov3 <= 0;
        end else begin
            m_oc1 <= oc_raw; m_oc2 <= m_oc1; m_oc3 <= m_oc2;
            m_ov1 <= ov_raw; m_ov2 <= m_ov1; m_ov3 <= m_ov2;
            m_ss <= 0;
            if (!(en_ok && por_ok)) begin
                m_state <= 0; m_cnt <= 0; m_low <= 0;
            end else if (m_state == 0) begin
                m_state <= 1; m_ss <= 1;
            end else if (m_state == 1) begin
                if (m_ov2 && m_ov3) begin m_state <= 3; m_low <= 1; end
                else if (m_oc2 && m_oc3) begin m_state <= 2; m_cnt <= HCYC - 1; end
            end else if (m_state == 2) begin
                if (m_ov2 && m_ov3) begin m_state <= 3; m_low <= 1; m_cnt <= 0; end
                else if (m_cnt == 0) begin m_state <= 1; m_ss <= 1; end
                else m_cnt <= m_cnt - 1;
            end else begin
                m_low <= m_ov2 && m_ov3;
            end
        end
    end

    function automatic logic [2*NPH-1:0] all_mode(input logic [1:0] c);
        logic [2*NPH-1:0] v;
        for (int k = 0; k < NPH; k++) v[2*k +: 2] = c;
        return v;
    endfunction

    function automatic logic [1:0] exp_code();
        if (m_state == 1) return 2'b00;
        if (m_state == 3) return m_low ? 2'b01 : 2'b10;
        return 2'b10;
    endfunction

    function automatic string mode_tag();
        case (m_state)
            0: return "R9";
            1: return "R2";
            2: return "R4";
            default: return m_low ? "R6" : "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check(mode_tag(), 32'(phase_mode), 32'(all_mode(exp_code())));
            check("R8", 32'(ovp), 32'(m_state == 3));
            check("R5", 32'(ss_restart), 32'(m_ss));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int tri_cnt;
        bit seen_tri;
        cyc(2);
        // R1: reset state
        check("R1", 32'(phase_mode), 32'(all_mode(2'b10)));
        check("R1", 32'(ovp), 0);
        check("R1", 32'(ss_restart), 0);
        rst_n = 1'b1;
        cyc(3);
        check("R1", 32'(phase_mode), 32'(all_mode(2'b10)));
        check("R1", 32'(ss_restart), 0);
        chk_on = 1'b1;

        // R2: enable gives PWM and a one-cycle restart request
        en_ok = 1'b1;
        cyc(1);
        check("R2", 32'(ss_restart), 1);
        check("R2", 32'(phase_mode), 32'(all_mode(2'b00)));
        cyc(1);
        check("R2", 32'(ss_restart), 0);

        // R3: one-clock glitches are ignored
        oc_raw = 1'b1; cyc(1); oc_raw = 1'b0; cyc(6);
        check("R3", 32'(phase_mode), 32'(all_mode(2'b00)));
        ov_raw = 1'b1; cyc(1); ov_raw = 1'b0; cyc(6);
        check("R3", 32'(phase_mode), 32'(all_mode(2'b00)));
        check("R3", 32'(ovp), 0);

        // R3/R4/R5: two-clock overcurrent pulse, measure hiccup length
        oc_raw = 1'b1; cyc(2); oc_raw = 1'b0;
        cyc(1);
        check("R3", 32'(phase_mode), 32'(all_mode(2'b00)));
        cyc(1);
        check("R3", 32'(phase_mode), 32'(all_mode(2'b10)));
        tri_cnt = 0;
        while (phase_mode == all_mode(2'b10) && tri_cnt < 50) begin
            tri_cnt++;
            cyc(1);
        end
        check("R4", 32'(tri_cnt), 32'(HCYC));
        check("R5", 32'(ss_restart), 1);
        check("R5", 32'(phase_mode), 32'(all_mode(2'b00)));
        cyc(3);

        // R6/R7/R8: overvoltage with recurrence
        ov_raw = 1'b1; cyc(5);
        check("R6", 32'(phase_mode), 32'(all_mode(2'b01)));
        check("R6", 32'(ovp), 1);
        ov_raw = 1'b0; cyc(6);
        check("R7", 32'(phase_mode), 32'(all_mode(2'b10)));
        check("R8", 32'(ovp), 1);
        ov_raw = 1'b1; cyc(5);
        check("R7", 32'(phase_mode), 32'(all_mode(2'b01)));
        ov_raw = 1'b0; cyc(20);
        check("R8", 32'(phase_mode), 32'(all_mode(2'b10)));
        check("R8", 32'(ovp), 1);

        // R9: enable drop clears the latch, re-enable re-arms soft start
        en_ok = 1'b0; cyc(2);
        check("R9", 32'(ovp), 0);
        check("R9", 32'(phase_mode), 32'(all_mode(2'b10)));
        en_ok = 1'b1; cyc(1);
        check("R9", 32'(ss_restart), 1);
        check("R9", 32'(phase_mode), 32'(all_mode(2'b00)));
        cyc(2);

        // R10: both flags in the same cycle take the overvoltage path
        oc_raw = 1'b1; ov_raw = 1'b1; cyc(5);
        check("R10", 32'(phase_mode), 32'(all_mode(2'b01)));
        check("R10", 32'(ovp), 1);
        oc_raw = 1'b0; ov_raw = 1'b0; cyc(5);

        // R9: supply-good drop also clears; also abandon a hiccup wait
        por_ok = 1'b0; cyc(2);
        check("R9", 32'(ovp), 0);
        por_ok = 1'b1; cyc(3);
        oc_raw = 1'b1; cyc(2); oc_raw = 1'b0; cyc(4);
        check("R4", 32'(phase_mode), 32'(all_mode(2'b10)));
        en_ok = 1'b0; cyc(1);
        check("R9", 32'(phase_mode), 32'(all_mode(2'b10)));
        en_ok = 1'b1; cyc(1);
        check("R9", 32'(ss_restart), 1);
        cyc(3);

        // Sweep of pulse widths and gaps across the qualifier boundary
        for (int w = 1; w <= 4; w++) begin
            for (int gap = 1; gap <= 4; gap++) begin
                for (int which = 0; which < 2; which++) begin
                    if (which == 0) oc_raw = 1'b1; else ov_raw = 1'b1;
                    cyc(w);
                    oc_raw = 1'b0; ov_raw = 1'b0;
                    cyc(gap);
                    if (which == 0) oc_raw = 1'b1; else ov_raw = 1'b1;
                    cyc(w);
                    oc_raw = 1'b0; ov_raw = 1'b0;
                    cyc(HCYC + 8);
                    en_ok = 1'b0; cyc(2); en_ok = 1'b1; cyc(3);
                end
            end
        end

        // Random run
        seen_tri = 0;
        for (int i = 0; i < 4000; i++) begin
            oc_raw = ($urandom_range(0, 9) < 3);
            ov_raw = ($urandom_range(0, 29) < 2);
            if ($urandom_range(0, 199) == 0) en_ok = 1'b0;
            else if ($urandom_range(0, 3) == 0) en_ok = 1'b1;
            por_ok = ($urandom_range(0, 499) != 0);
            cyc(1);
        end
        oc_raw = 1'b0; ov_raw = 1'b0; en_ok = 1'b1; por_ok = 1'b1;
        cyc(20);
        chk_on = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule